// File: doc/BRIEF.md
# Status Ring Producer with Wrap Stamping

This block turns status requests into fixed-size entries of eight 32-bit words and writes them, one word per clock, into a circular buffer in memory. The buffer starts at a configured byte address and holds a configured number of slots. The block keeps a head index that advances by one slot after every finished entry and returns to slot 0 after the last slot. A request is accepted through a valid/ready handshake. Ready is withheld while an entry is being written. It is also withheld when the next head position would meet the consumer's tail index, so a slot that has not been released is never overwritten.

The last word of every entry carries a 4-bit pass counter and a ring identifier. The counter is 0 after reset and advances each time the head wraps, so it rolls from 15 back to 0. Its low bit flips on every pass. A consumer can therefore find where fresh entries end by comparing that one bit, without reading the head index. The stamp word is written last, and a one-clock interrupt pulse follows it, so an entry never looks fresh before its other seven words are in memory.

Top module: `status_ring_producer`

## Requirements
- R1: After reset, head_idx is 0, the pass counter is 0, mem_wr_en and entry_irq are low, and req_ready is high when the ring is empty (tail_idx equal to head_idx).
- R2: Each accepted request writes exactly 8 words on 8 consecutive clocks, starting the clock after acceptance. Word k of slot s goes to byte address cfg_base + 32*s + 4*k, in order k = 0 to 7.
- R3: Word 0 holds the operation code in bits 3:0, the engine-select bit in bit 4, the result code in bits 6:5, the index-mode bit in bit 7 and the 24-bit count in bits 31:8.
- R4: The count (word 0 bits 31:8), the byte count (word 1) and the timestamp (word 2) are written as given only for operation codes 7 and 8. For every other code they are written as zero.
- R5: Word 3 holds metadata bits 31:0 and word 4 holds metadata bits 63:32. Word 5 holds the 20-bit hash in bits 19:0, the set number in bits 23:20 and zero in bits 31:24. Word 6 is all zero.
- R6: Word 7 holds zero in bits 19:0, the ring identifier captured at acceptance in bits 27:20, and the pass counter in bits 31:28.
- R7: head_idx holds during an entry. It changes on the clock edge that ends word 7, to head_idx+1, or to 0 when head_idx equals cfg_last (the ring has cfg_last+1 slots).
- R8: The pass counter stamped into word 7 is the count of head wraps since reset, modulo 16. It steps on the same edge on which head_idx returns to 0 and goes from 15 to 0.
- R9: entry_irq is high for exactly one clock, the clock after word 7 is written.
- R10: req_ready is low while an entry is being written. A request presented during that time is not taken, and its fields do not affect the entry in progress.
- R11: req_ready is low whenever the slot after head_idx equals tail_idx. Acceptance resumes once tail_idx moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_base | input | ADDR_W | Byte address of slot 0 |
| cfg_last | input | IDX_W | Index of the last slot (slots minus one) |
| cfg_ring_id | input | 8 | Ring identifier stamped into word 7 |
| tail_idx | input | IDX_W | Consumer's release index |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_opcode | input | 4 | Operation code |
| req_eng_sel | input | 1 | Engine select |
| req_result | input | 2 | Result code (0 done, 1 not found, 2 timeout) |
| req_idx_mode | input | 1 | Index-mode flag |
| req_count | input | 24 | Entry count statistic |
| req_bytes | input | 32 | Byte count statistic |
| req_tstamp | input | 32 | Timestamp statistic |
| req_meta | input | 64 | Metadata passed through |
| req_hash | input | 20 | Hash index value |
| req_set | input | 4 | Set number |
| mem_wr_en | output | 1 | Word write strobe |
| mem_wr_addr | output | ADDR_W | Byte address of the write |
| mem_wr_data | output | 32 | Word written |
| head_idx | output | IDX_W | Next slot to be written |
| entry_irq | output | 1 | One-clock pulse after an entry completes |

## Verification
The bench runs enough entries through a three-slot ring to take the pass counter past 15. A design that saturated the counter, or stepped it on every entry instead of on every wrap, stamps the wrong value into word 7. Requests are held valid across busy periods with fresh field values, so a design that accepts while writing, or re-reads live inputs during an entry, corrupts the data or starts a ninth write. The bench freezes the tail to fill the ring and checks that ready drops one slot short of the tail, where an off-by-one would overwrite an unreleased slot. Operation codes on both sides of 7 and 8 expose statistics fields that are gated wrongly.

// File: rtl/srp_pkg.sv
package srp_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 8;
  localparam int WSEL_W      = $clog2(ENTRY_WORDS);
  localparam int PASS_W      = 4;

  // Request fields held for the duration of one entry
  typedef struct packed {
    logic [3:0]  opcode;
    logic        eng_sel;
    logic [1:0]  result;
    logic        idx_mode;
    logic [23:0] count;
    logic [31:0] bytes;
    logic [31:0] tstamp;
    logic [63:0] meta;
    logic [19:0] hash;
    logic [3:0]  set_num;
    logic [7:0]  ring_id;
  } srp_req_t;

  // Statistics fields are meaningful only for these two operation codes
  function automatic logic carries_stats(input logic [3:0] op);
    return (op == 4'd7) || (op == 4'd8);
  endfunction
endpackage

// File: rtl/srp_entry_pack.sv
module srp_entry_pack
  import srp_pkg::*;
(
  input  srp_req_t              req,
  input  logic [PASS_W-1:0]     pass_cnt,
  input  logic [WSEL_W-1:0]     wsel,
  output logic [WORD_W-1:0]     word
);
  logic [ENTRY_WORDS-1:0][WORD_W-1:0] words;
  logic        stats_on;
  logic [23:0] cnt_f;
  logic [31:0] bytes_f;
  logic [31:0] tstamp_f;

  always_comb begin
    stats_on = carries_stats(req.opcode);
    cnt_f    = stats_on ? req.count  : '0;
    bytes_f  = stats_on ? req.bytes  : '0;
    tstamp_f = stats_on ? req.tstamp : '0;
    words[0] = {cnt_f, req.idx_mode, req.result, req.eng_sel, req.opcode};
    words[1] = bytes_f;
    words[2] = tstamp_f;
    words[3] = req.meta[31:0];
    words[4] = req.meta[63:32];
    words[5] = {8'h00, req.set_num, req.hash};
    words[6] = '0;
    words[7] = {pass_cnt, req.ring_id, 20'h00000};
  end

  assign word = words[wsel];
endmodule

// File: rtl/srp_head_ctrl.sv
module srp_head_ctrl
  import srp_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              advance,
  output logic [IDX_W-1:0]  head_idx,
  output logic [PASS_W-1:0] pass_cnt,
  output logic              ring_full
);
  logic [IDX_W-1:0]  head_q, head_d, head_inc;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic              at_last;

  always_comb begin
    at_last  = (head_q == cfg_last);
    head_inc = at_last ? '0 : head_q + IDX_W'(1);
    head_d   = head_q;
    pass_d   = pass_q;
    if (advance) begin
      head_d = head_inc;
      if (at_last) pass_d = pass_q + PASS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      pass_q <= '0;
    end else if (advance) begin
      head_q <= head_d;
      pass_q <= pass_d;
    end
  end

  assign head_idx  = head_q;
  assign pass_cnt  = pass_q;
  assign ring_full = (head_inc == tail_idx);

  p_head_wraps_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance && at_last |=> head_q == '0);
  p_pass_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    advance && at_last |=> pass_q == PASS_W'($past(pass_q) + PASS_W'(1)));
  p_pass_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance && at_last) |=> $stable(pass_q));
endmodule

// File: rtl/srp_write_seq.sv
module srp_write_seq
  import srp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              ring_full,
  output logic              req_ready,
  output logic              accept,
  output logic              wr_en,
  output logic [WSEL_W-1:0] wsel,
  output logic              advance,
  output logic              irq
);
  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(ENTRY_WORDS - 1);

  logic              busy_q, busy_d;
  logic [WSEL_W-1:0] wsel_q, wsel_d;
  logic              irq_q, irq_d;
  logic              last;

  always_comb begin
    req_ready = !busy_q && !ring_full;
    accept    = req_valid && req_ready;
    last      = busy_q && (wsel_q == LAST_WORD);
    busy_d    = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (last) busy_d = 1'b0;
    wsel_d    = wsel_q + WSEL_W'(1);
    irq_d     = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wsel_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      irq_q  <= irq_d;
      if (busy_q) wsel_q <= wsel_d;
    end
  end

  assign wr_en   = busy_q;
  assign wsel    = wsel_q;
  assign advance = last;
  assign irq     = irq_q;

  p_accept_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> wr_en && wsel == '0);
  p_writes_contiguous_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !last |=> wr_en && wsel == WSEL_W'($past(wsel) + WSEL_W'(1)));
  p_irq_follows_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> irq);
  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

// File: rtl/status_ring_producer.sv
module status_ring_producer
  import srp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_last,
  input  logic [7:0]        cfg_ring_id,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_opcode,
  input  logic              req_eng_sel,
  input  logic [1:0]        req_result,
  input  logic              req_idx_mode,
  input  logic [23:0]       req_count,
  input  logic [31:0]       req_bytes,
  input  logic [31:0]       req_tstamp,
  input  logic [63:0]       req_meta,
  input  logic [19:0]       req_hash,
  input  logic [3:0]        req_set,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [WORD_W-1:0] mem_wr_data,
  output logic [IDX_W-1:0]  head_idx,
  output logic              entry_irq
);
  localparam int OFS_W = IDX_W + WSEL_W + 2;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic              accept, advance, ring_full;
  logic [WSEL_W-1:0] wsel;
  logic [PASS_W-1:0] pass_cnt;
  srp_req_t          req_in, req_q;
  logic [OFS_W-1:0]  ofs;

  always_comb begin
    req_in.opcode   = req_opcode;
    req_in.eng_sel  = req_eng_sel;
    req_in.result   = req_result;
    req_in.idx_mode = req_idx_mode;
    req_in.count    = req_count;
    req_in.bytes    = req_bytes;
    req_in.tstamp   = req_tstamp;
    req_in.meta     = req_meta;
    req_in.hash     = req_hash;
    req_in.set_num  = req_set;
    req_in.ring_id  = cfg_ring_id;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  req_q <= '0;
    else if (accept)  req_q <= req_in;
  end

  srp_write_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .ring_full (ring_full),
    .req_ready (req_ready),
    .accept    (accept),
    .wr_en     (mem_wr_en),
    .wsel      (wsel),
    .advance   (advance),
    .irq       (entry_irq)
  );

  srp_head_ctrl #(.IDX_W(IDX_W)) u_head (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_last  (cfg_last),
    .tail_idx  (tail_idx),
    .advance   (advance),
    .head_idx  (head_idx),
    .pass_cnt  (pass_cnt),
    .ring_full (ring_full)
  );

  srp_entry_pack u_pack (
    .req      (req_q),
    .pass_cnt (pass_cnt),
    .wsel     (wsel),
    .word     (mem_wr_data)
  );

  assign ofs         = {head_idx, wsel, 2'b00};
  assign mem_wr_addr = cfg_base + {{(ADDR_W - OFS_W){1'b0}}, ofs};

  p_stamp_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en && wsel == WSEL_W'(ENTRY_WORDS - 1) |-> mem_wr_data[19:0] == 20'h0);
  p_word6_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en && wsel == WSEL_W'(6) |-> mem_wr_data == '0);
  p_head_holds_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_wr_en && wsel != WSEL_W'(ENTRY_WORDS - 1) |=> $stable(head_idx));
  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    accept |=> !req_ready);
endmodule

// File: tb/status_ring_producer_bench.sv
module status_ring_producer_bench;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] cfg_base = 32'h0001_0000;
  logic [IDX_W-1:0]  cfg_last = 8'd2;
  logic [7:0]        cfg_ring_id = 8'hA5;
  logic [IDX_W-1:0]  tail_idx = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [3:0]        req_opcode = '0;
  logic              req_eng_sel = 1'b0;
  logic [1:0]        req_result = '0;
  logic              req_idx_mode = 1'b0;
  logic [23:0]       req_count = '0;
  logic [31:0]       req_bytes = '0;
  logic [31:0]       req_tstamp = '0;
  logic [63:0]       req_meta = '0;
  logic [19:0]       req_hash = '0;
  logic [3:0]        req_set = '0;
  logic              mem_wr_en;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [31:0]       mem_wr_data;
  logic [IDX_W-1:0]  head_idx;
  logic              entry_irq;

  always #10 clk = ~clk;

  status_ring_producer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_status_ring_producer (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_last(cfg_last),
    .cfg_ring_id(cfg_ring_id), .tail_idx(tail_idx), .req_valid(req_valid),
    .req_ready(req_ready), .req_opcode(req_opcode), .req_eng_sel(req_eng_sel),
    .req_result(req_result), .req_idx_mode(req_idx_mode), .req_count(req_count),
    .req_bytes(req_bytes), .req_tstamp(req_tstamp), .req_meta(req_meta),
    .req_hash(req_hash), .req_set(req_set), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .head_idx(head_idx),
    .entry_irq(entry_irq)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // Behavioural reference model
  int          m_phase;   // -1 idle, 0..7 word being written
  int          m_head;
  int          m_pass;
  bit          m_irq;
  bit          m_took;
  logic [3:0]  c_op;
  logic        c_sel, c_idx;
  logic [1:0]  c_res;
  logic [23:0] c_cnt;
  logic [31:0] c_bytes, c_ts;
  logic [63:0] c_meta;
  logic [19:0] c_hash;
  logic [3:0]  c_set;
  logic [7:0]  c_rid;

  function automatic int next_slot(int h);
    return (h == int'(cfg_last)) ? 0 : h + 1;
  endfunction

  function automatic bit model_ready();
    return (m_phase < 0) && (next_slot(m_head) != int'(tail_idx));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = -1; m_head = 0; m_pass = 0; m_irq = 0; m_took = 0;
      c_op = 0; c_sel = 0; c_idx = 0; c_res = 0; c_cnt = 0; c_bytes = 0;
      c_ts = 0; c_meta = 0; c_hash = 0; c_set = 0; c_rid = 0;
    end else begin
      bit rdy;
      rdy    = model_ready();
      m_took = 0;
      m_irq  = (m_phase == 7);
      if (m_phase == 7) begin
        m_phase = -1;
        if (m_head == int'(cfg_last)) begin
          m_head = 0;
          m_pass = (m_pass + 1) % 16;
        end else m_head = m_head + 1;
      end else if (m_phase >= 0) begin
        m_phase = m_phase + 1;
      end else if (req_valid && rdy) begin
        m_took = 1; m_phase = 0;
        c_op = req_opcode; c_sel = req_eng_sel; c_idx = req_idx_mode;
        c_res = req_result; c_cnt = req_count; c_bytes = req_bytes;
        c_ts = req_tstamp; c_meta = req_meta; c_hash = req_hash;
        c_set = req_set; c_rid = cfg_ring_id;
      end
    end
  end

  function automatic logic [31:0] exp_word(int p);
    bit st;
    st = (c_op == 4'd7) || (c_op == 4'd8);
    case (p)
      0: return ((st ? 32'(c_cnt) : 32'd0) << 8) | (32'(c_idx) << 7)
                | (32'(c_res) << 5) | (32'(c_sel) << 4) | 32'(c_op);
      1: return st ? c_bytes : 32'd0;
      2: return st ? c_ts : 32'd0;
      3: return c_meta[31:0];
      4: return c_meta[63:32];
      5: return (32'(c_set) << 20) | 32'(c_hash);
      6: return 32'd0;
      default: return (32'(m_pass) << 28) | (32'(c_rid) << 20);
    endcase
  endfunction

  function automatic string word_tag(int p);
    case (p)
      0: return "R3 R4";
      1, 2: return "R4";
      3, 4, 5, 6: return "R5";
      default: return "R6 R8";
    endcase
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  bit in_reset_window = 1;

  always @(negedge clk) begin
    cycles++;
    if (!done && cycles > 2) begin
      bit er;
      string rtag;
      er = model_ready();
      if (in_reset_window) begin
        check("R1", "ready", 32'(req_ready), 32'(er));
        check("R1", "wr_en", 32'(mem_wr_en), 32'd0);
        check("R1", "head", 32'(head_idx), 32'd0);
        check("R1", "irq", 32'(entry_irq), 32'd0);
      end else begin
        rtag = (m_phase < 0 && !er) ? "R11" : "R10";
        check(rtag, "ready", 32'(req_ready), 32'(er));
        check("R2", "wr_en", 32'(mem_wr_en), 32'(m_phase >= 0));
        if (m_phase >= 0) begin
          check("R2", "addr", mem_wr_addr,
                cfg_base + 32'(m_head * 32 + m_phase * 4));
          check(word_tag(m_phase), "data", mem_wr_data, exp_word(m_phase));
        end
        check("R7", "head", 32'(head_idx), 32'(m_head));
        check("R9", "irq", 32'(entry_irq), 32'(m_irq));
      end
    end
  end

  bit tail_follow = 1;
  always @(negedge clk) begin
    #1;
    if (tail_follow) tail_idx <= IDX_W'(m_head);
  end

  task automatic send(logic [3:0] op);
    @(negedge clk); #2;
    req_valid    = 1'b1;
    req_opcode   = op;
    req_eng_sel  = 1'($urandom);
    req_result   = 2'($urandom % 3);
    req_idx_mode = 1'($urandom);
    req_count    = 24'($urandom);
    req_bytes    = $urandom;
    req_tstamp   = $urandom;
    req_meta     = {$urandom, $urandom};
    req_hash     = 20'($urandom);
    req_set      = 4'($urandom);
    forever begin
      @(negedge clk); #2;
      if (m_took) break;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3 in_reset_window = 0;
    // R3 R4: every legal opcode, back to back, valid held through busy (R10)
    for (int i = 0; i < 9; i++) send(4'(i));
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    // R8: run well past 16 wraps of a three-slot ring
    for (int i = 0; i < 54; i++) begin
      send(4'((i % 3 == 0) ? 7 : (i % 3 == 1) ? 8 : (i % 9)));
      if (i % 5 == 0) begin
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    // R11: consumer stops releasing; ring fills one short of the tail
    tail_follow = 0;
    #2;
    req_valid = 1'b1;
    repeat (60) @(negedge clk);
    tail_follow = 1;
    repeat (40) @(negedge clk);
    req_valid = 1'b0;
    cfg_ring_id = 8'h3C;
    send(4'd7);
    req_valid = 1'b0;
    repeat (15) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule